// File: doc/BRIEF.md
# Nonvolatile-Backed SRAM with Software Store and Recall

This block models a byte-wide static RAM in which every word has a partner word in a shadow nonvolatile array, and it runs on a system clock. A bus master uses active-low chip-select, output-enable and write-enable strobes to read and write it like any SRAM. Each clock cycle with chip-select low counts as one access. Read data appears one cycle after the read cycle, with a qualifying enable flag.

Copies between the two arrays are started in software. The master issues six read cycles at fixed addresses. The first five addresses are shared. The sixth selects STORE, which copies the SRAM into the shadow, or RECALL, which zeroes the SRAM and then reloads it from the shadow. Any write, or any read that does not fit the sequence, restarts detection. While a copy is in progress, a busy flag is high and the bus is locked out. A RECALL also runs by itself when reset is released. The shadow starts out erased (all zero).

Each copy moves one word per clock. A parameterised settle count then stands in for the real nonvolatile programming or reload time. The address width is a parameter. The default is 10 bits, which keeps elaboration small. A width of 13 gives the full 8192 x 8 organisation.

Top module: `nvs_sram_top`

## Requirements
- R1: The block holds 2**ADDR_W words of DATA_W bits each (1024 x 8 by default, 8192 x 8 with ADDR_W = 13), and a read returns the last value written to that address.
- R2: When ce_n is high, the cycle is standby: dout_en goes low one cycle later, and a low we_n does not change memory.
- R3: A cycle with ce_n low and we_n low (and not busy) writes din to addr at that clock edge, and dout_en is low one cycle later.
- R4: A cycle with ce_n low, we_n high and oe_n low (not busy) gives dout = the addressed word and dout_en high one cycle later. With oe_n high, dout_en is low instead.
- R5: A STORE or RECALL starts at the clock edge of the sixth of six consecutive read cycles. The first five read addresses are SEQ0..SEQ4 (defaults 0x0E3, 0x3C1, 0x29A, 0x165, 0x0F0). The sixth is STORE_LAST (default 0x30F) for STORE or RECALL_LAST (default 0x0C3) for RECALL. busy goes high one cycle after that edge.
- R6: A write, or a read that does not match the next expected address, aborts a partial sequence. A read at SEQ0 restarts detection at step two. Standby cycles between steps do not abort.
- R7: While busy is high, reads leave dout_en low, writes do not alter memory, and sequence reads do not start a further operation.
- R8: STORE copies every SRAM word into the shadow. busy stays high for exactly 2**ADDR_W + WAIT_CYC cycles, and the SRAM stays readable and writable afterwards.
- R9: RECALL clears every SRAM word to zero and then loads the shadow contents. It leaves the shadow unchanged, and busy stays high for exactly 2*2**ADDR_W + WAIT_CYC cycles.
- R10: busy is high during reset and for 2*2**ADDR_W + WAIT_CYC cycles after reset is released, while an automatic RECALL runs. The erased shadow reads back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the automatic RECALL |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, registered |
| dout_en | output | 1 | High when dout carries valid read data (models the drivers being on) |
| busy | output | 1 | High while a STORE or RECALL is running |

## Verification
The hardest situation to reach is the lockout window. Accesses, including a complete trigger sequence, must land while a copy is running and still be shown to have had no effect. The bench issues the trigger, then drives a blind access on every busy cycle: the full RECALL sequence first, then random writes. It counts the busy cycles against the expected length, confirms no second operation follows, and later reads back every word of the array. Aborted sequences are built from a full prefix that is broken either by a write or by a stray read, so the only thing that differs from a successful trigger is the intruding access.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_STORE,
        ENG_CLEAR,
        ENG_LOAD,
        ENG_SETTLE
    } eng_state_e;
endpackage

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    // erased state of the cells at power-up
    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = '0;
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect #(
    parameter int          ADDR_W      = 10,
    parameter int unsigned SEQ0        = 32'h0E3,
    parameter int unsigned SEQ1        = 32'h3C1,
    parameter int unsigned SEQ2        = 32'h29A,
    parameter int unsigned SEQ3        = 32'h165,
    parameter int unsigned SEQ4        = 32'h0F0,
    parameter int unsigned STORE_LAST  = 32'h30F,
    parameter int unsigned RECALL_LAST = 32'h0C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              acc_i,
    input  logic              is_read_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              store_go_o,
    output logic              recall_go_o
);
    localparam int STEPS = 5;
    localparam logic [ADDR_W-1:0] STEP_ADDR [STEPS] = '{
        ADDR_W'(SEQ0), ADDR_W'(SEQ1), ADDR_W'(SEQ2), ADDR_W'(SEQ3), ADDR_W'(SEQ4)
    };
    localparam logic [ADDR_W-1:0] STORE_A  = ADDR_W'(STORE_LAST);
    localparam logic [ADDR_W-1:0] RECALL_A = ADDR_W'(RECALL_LAST);

    typedef struct packed {
        logic [2:0] idx;
    } det_t;

    det_t det_d, det_q;
    logic [STEPS-1:0] step_hit;
    logic             exp_hit;

    for (genvar k = 0; k < STEPS; k++) begin : g_cmp
        assign step_hit[k] = (addr_i == STEP_ADDR[k]);
    end

    always_comb begin
        exp_hit = 1'b0;
        for (int k = 0; k < STEPS; k++) begin
            if (det_q.idx == 3'(k)) exp_hit = step_hit[k];
        end
    end

    always_comb begin
        det_d       = det_q;
        store_go_o  = 1'b0;
        recall_go_o = 1'b0;
        if (flush_i) begin
            det_d.idx = '0;
        end else if (acc_i) begin
            if (!is_read_i) begin
                det_d.idx = '0;
            end else if (det_q.idx == 3'(STEPS)) begin
                store_go_o  = (addr_i == STORE_A);
                recall_go_o = (addr_i == RECALL_A) && (addr_i != STORE_A);
                if (store_go_o || recall_go_o) det_d.idx = '0;
                else det_d.idx = step_hit[0] ? 3'd1 : 3'd0;
            end else if (exp_hit) begin
                det_d.idx = det_q.idx + 3'd1;
            end else begin
                det_d.idx = step_hit[0] ? 3'd1 : 3'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end
endmodule

// File: rtl/nvs_copy_engine.sv
module nvs_copy_engine
    import nvs_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int WAIT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_go_i,
    input  logic              recall_go_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              sram_we_o,
    output logic              from_shadow_o,
    output logic              shadow_we_o
);
    localparam int WAIT_W = $clog2(WAIT_CYC + 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_CYC - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [ADDR_W-1:0] cnt;
        logic [WAIT_W-1:0] wc;
    } eng_t;

    eng_t eng_d, eng_q;
    logic last_word;

    assign last_word = &eng_q.cnt;

    always_comb begin
        eng_d = eng_q;
        case (eng_q.st)
            ENG_IDLE: begin
                eng_d.cnt = '0;
                if (store_go_i)       eng_d.st = ENG_STORE;
                else if (recall_go_i) eng_d.st = ENG_CLEAR;
            end
            ENG_STORE: begin
                eng_d.cnt = eng_q.cnt + 1'b1;
                if (last_word) begin
                    eng_d.st = ENG_SETTLE;
                    eng_d.wc = '0;
                end
            end
            ENG_CLEAR: begin
                eng_d.cnt = eng_q.cnt + 1'b1;
                if (last_word) eng_d.st = ENG_LOAD;
            end
            ENG_LOAD: begin
                eng_d.cnt = eng_q.cnt + 1'b1;
                if (last_word) begin
                    eng_d.st = ENG_SETTLE;
                    eng_d.wc = '0;
                end
            end
            ENG_SETTLE: begin
                if (eng_q.wc == WAIT_LAST) eng_d.st = ENG_IDLE;
                else                       eng_d.wc = eng_q.wc + 1'b1;
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q.st  <= ENG_CLEAR;
            eng_q.cnt <= '0;
            eng_q.wc  <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy_o        = (eng_q.st != ENG_IDLE);
    assign addr_o        = eng_q.cnt;
    assign sram_we_o     = (eng_q.st == ENG_CLEAR) || (eng_q.st == ENG_LOAD);
    assign from_shadow_o = (eng_q.st == ENG_LOAD);
    assign shadow_we_o   = (eng_q.st == ENG_STORE);
endmodule

// File: rtl/nvs_sram_top.sv
module nvs_sram_top #(
    parameter int          ADDR_W      = 10,
    parameter int          DATA_W      = 8,
    parameter int          WAIT_CYC    = 16,
    parameter int unsigned SEQ0        = 32'h0E3,
    parameter int unsigned SEQ1        = 32'h3C1,
    parameter int unsigned SEQ2        = 32'h29A,
    parameter int unsigned SEQ3        = 32'h165,
    parameter int unsigned SEQ4        = 32'h0F0,
    parameter int unsigned STORE_LAST  = 32'h30F,
    parameter int unsigned RECALL_LAST = 32'h0C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy
);
    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic              dout_en;
    } bus_t;

    bus_t bus_d, bus_q;

    logic              acc, rd_acc, wr_acc;
    logic              store_go, recall_go;
    logic              eng_busy, eng_sram_we, eng_from_shadow, eng_shadow_we;
    logic [ADDR_W-1:0] eng_addr;
    logic              sram_we;
    logic [ADDR_W-1:0] sram_waddr;
    logic [DATA_W-1:0] sram_wdata, sram_bus_rd, sram_eng_rd;
    logic [DATA_W-1:0] shadow_rd, shadow_rd_unused;

    assign acc    = !ce_n && !eng_busy;
    assign rd_acc = acc && we_n;
    assign wr_acc = acc && !we_n;

    nvs_seq_detect #(
        .ADDR_W(ADDR_W), .SEQ0(SEQ0), .SEQ1(SEQ1), .SEQ2(SEQ2), .SEQ3(SEQ3),
        .SEQ4(SEQ4), .STORE_LAST(STORE_LAST), .RECALL_LAST(RECALL_LAST)
    ) i_det (
        .clk(clk), .rst_n(rst_n), .flush_i(eng_busy), .acc_i(acc),
        .is_read_i(we_n), .addr_i(addr),
        .store_go_o(store_go), .recall_go_o(recall_go)
    );

    nvs_copy_engine #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) i_eng (
        .clk(clk), .rst_n(rst_n), .store_go_i(store_go), .recall_go_i(recall_go),
        .busy_o(eng_busy), .addr_o(eng_addr), .sram_we_o(eng_sram_we),
        .from_shadow_o(eng_from_shadow), .shadow_we_o(eng_shadow_we)
    );

    always_comb begin
        sram_we    = eng_sram_we || wr_acc;
        sram_waddr = eng_busy ? eng_addr : addr;
        if (eng_from_shadow)  sram_wdata = shadow_rd;
        else if (eng_sram_we) sram_wdata = '0;
        else                  sram_wdata = din;
    end

    nvs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sram (
        .clk(clk), .we(sram_we), .waddr(sram_waddr), .wdata(sram_wdata),
        .raddr_a(addr), .rdata_a(sram_bus_rd),
        .raddr_b(eng_addr), .rdata_b(sram_eng_rd)
    );

    nvs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_shadow (
        .clk(clk), .we(eng_shadow_we), .waddr(eng_addr), .wdata(sram_eng_rd),
        .raddr_a(eng_addr), .rdata_a(shadow_rd),
        .raddr_b(eng_addr), .rdata_b(shadow_rd_unused)
    );

    always_comb begin
        bus_d         = bus_q;
        bus_d.dout_en = rd_acc && !oe_n;
        if (rd_acc && !oe_n) bus_d.dout = sram_bus_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign dout    = bus_q.dout;
    assign dout_en = bus_q.dout_en;
    assign busy    = eng_busy;

    logic unused_ok;
    assign unused_ok = ^shadow_rd_unused;
endmodule

// File: rtl/nvs_sram_chk.sv
module nvs_sram_chk #(
    parameter int          ADDR_W      = 10,
    parameter int unsigned STORE_LAST  = 32'h30F,
    parameter int unsigned RECALL_LAST = 32'h0C3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              dout_en,
    input logic              busy
);
    // R2
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dout_en);
    // R3
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> !dout_en);
    // R4
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && oe_n) |=> !dout_en);
    // R4
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n && !busy) |=> dout_en);
    // R7
    busy_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !dout_en);
    // R5
    trigger_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(!ce_n && we_n) &&
            ($past(addr) == ADDR_W'(STORE_LAST) || $past(addr) == ADDR_W'(RECALL_LAST))));
endmodule

bind nvs_sram_top nvs_sram_chk #(
    .ADDR_W(ADDR_W), .STORE_LAST(STORE_LAST), .RECALL_LAST(RECALL_LAST)
) i_nvs_sram_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dout_en(dout_en), .busy(busy)
);

// File: tb/test_nvs_sram_top.sv
module test_nvs_sram_top;
    localparam int AW    = 10;
    localparam int DW    = 8;
    localparam int WAITC = 16;
    localparam int WORDS = 1 << AW;
    localparam logic [AW-1:0] SQ [5] = '{10'h0E3, 10'h3C1, 10'h29A, 10'h165, 10'h0F0};
    localparam logic [AW-1:0] ST_A = 10'h30F;
    localparam logic [AW-1:0] RC_A = 10'h0C3;

    logic          clk = 1'b0;
    logic          rst_n, ce_n, oe_n, we_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din, dout;
    logic          dout_en, busy;

    int  n_chk = 0, n_fail = 0;
    bit  finished = 1'b0;
    logic [DW-1:0] model [WORDS];
    logic [DW-1:0] snap  [WORDS];

    always #5 clk = ~clk;

    nvs_sram_top i_nvs_sram_top (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    function automatic logic [AW-1:0] rand_addr();
        logic [AW-1:0] a;
        a = AW'($urandom_range(WORDS - 1));
        return a;
    endfunction

    function automatic int rd_expect(logic [AW-1:0] a);
        return {23'd0, 1'b1, model[a]};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
        @(negedge clk);
        check(dout_en == 1'b0, "R3 write leaves outputs off", int'(dout_en), 0);
        model[a] = d;
        go_idle();
    endtask

    task automatic do_read(logic [AW-1:0] a, string req);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
        @(negedge clk);
        check(dout_en === 1'b1 && dout === model[a], req,
              int'({dout_en, dout}), rd_expect(a));
        go_idle();
    endtask

    task automatic blind(int k);
        ce_n = 1'b0; oe_n = 1'b0;
        if (k < 5)       begin we_n = 1'b1; addr = SQ[k]; end
        else if (k == 5) begin we_n = 1'b1; addr = RC_A; end
        else if (k[0])   begin we_n = 1'b0; addr = rand_addr(); din = DW'($urandom); end
        else             begin we_n = 1'b1; addr = rand_addr(); end
        @(negedge clk);
        check(dout_en == 1'b0, "R7 access during busy ignored", int'(dout_en), 0);
        go_idle();
    endtask

    task automatic run_op(logic [AW-1:0] last, int exp_len, string req);
        int len;
        for (int i = 0; i < 5; i++) begin
            do_read(SQ[i], "R4 sequence read data");
            if (last == ST_A) @(negedge clk);   // standby gaps must not abort (R6)
        end
        do_read(last, "R4 trigger read data");
        check(busy == 1'b1, "R5 busy after sixth read", int'(busy), 1);
        len = busy ? 1 : 0;
        for (int k = 0; busy && k < 4 * WORDS; k++) begin
            blind(k);
            if (busy) len++;
        end
        check(len == exp_len, req, len, exp_len);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R7 sequence during busy started nothing", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int len;
        void'($urandom(32'd2024));
        rst_n = 1'b0; go_idle(); addr = '0; din = '0;
        for (int i = 0; i < WORDS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R10 busy in reset", int'(busy), 1);
        check(dout_en == 1'b0, "R10 outputs off in reset", int'(dout_en), 0);
        rst_n = 1'b1;
        len = 0;
        for (int k = 0; busy && k < 4 * WORDS; k++) begin
            len++;
            @(negedge clk);
        end
        check(len == 2 * WORDS + WAITC, "R10 power-up recall length", len, 2 * WORDS + WAITC);
        for (int i = 0; i < 16; i++) do_read(rand_addr(), "R10 erased shadow reads zero");

        // R1 R3 R4 random traffic
        for (int i = 0; i < 300; i++) do_write(rand_addr(), DW'($urandom));
        for (int i = 0; i < 200; i++) begin
            if ($urandom_range(3) == 0) do_write(rand_addr(), DW'($urandom));
            else do_read(rand_addr(), "R1 read returns last write");
        end
        do_write(10'h3FF, 8'hA5);
        do_write(10'h000, 8'h5A);
        do_read(10'h3FF, "R1 top address");
        do_read(10'h000, "R1 bottom address");

        // R4 output enable high
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = 10'h3FF;
        @(negedge clk);
        check(dout_en == 1'b0, "R4 oe_n high keeps outputs off", int'(dout_en), 0);
        go_idle();
        // R2 standby with write strobe low
        ce_n = 1'b1; we_n = 1'b0; addr = 10'h3FF; din = 8'h00;
        @(negedge clk);
        check(dout_en == 1'b0, "R2 standby outputs off", int'(dout_en), 0);
        go_idle();
        do_read(10'h3FF, "R2 standby write ignored");

        // R6 abort by write
        for (int i = 0; i < 5; i++) do_read(SQ[i], "R6 prefix read");
        do_write(10'h011, 8'h3C);
        do_read(ST_A, "R6 final read");
        @(negedge clk);
        check(busy == 1'b0, "R6 write aborts sequence", int'(busy), 0);
        // R6 abort by stray read
        for (int i = 0; i < 3; i++) do_read(SQ[i], "R6 prefix read");
        do_read(10'h001, "R6 stray read");
        do_read(SQ[3], "R6 prefix read");
        do_read(SQ[4], "R6 prefix read");
        do_read(RC_A, "R6 final read");
        @(negedge clk);
        check(busy == 1'b0, "R6 stray read aborts sequence", int'(busy), 0);

        // R8 store
        run_op(ST_A, WORDS + WAITC, "R8 store busy length");
        for (int i = 0; i < WORDS; i++) snap[i] = model[i];
        // R8 sram usable after store; corrupt contents
        for (int i = 0; i < 200; i++) do_write(rand_addr(), DW'($urandom));
        for (int i = 0; i < 20; i++) do_read(rand_addr(), "R8 sram usable after store");

        // R9 recall
        run_op(RC_A, 2 * WORDS + WAITC, "R9 recall busy length");
        for (int i = 0; i < WORDS; i++) model[i] = snap[i];
        for (int i = 0; i < WORDS; i++) do_read(AW'(i), "R9 recall restores stored image");

        // R9 second recall: shadow unchanged by first recall
        for (int i = 0; i < 100; i++) do_write(rand_addr(), DW'($urandom));
        run_op(RC_A, 2 * WORDS + WAITC, "R9 second recall length");
        for (int i = 0; i < WORDS; i++) model[i] = snap[i];
        for (int i = 0; i < WORDS; i++) do_read(AW'(i), "R9 shadow unchanged by recall");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule